// File: doc/BRIEF.md
# Byte FIFO Bypass Port with Firmware Ownership

This block gives a small controller byte-wide register access to six endpoint byte FIFOs. Normally a streaming engine owns those FIFOs. One data register serves both directions. A write to it pushes the byte into the chosen FIFO, and a read from it pops the head of the chosen FIFO. A separate register holds a 3-bit select code. The code-to-FIFO mapping is not linear, and two of the codes select nothing.

A control register holds three things. An ownership bit hands the FIFOs to firmware. A direction bit picks push or pop. Two flush bits empty the selected FIFO and clear themselves one cycle later. When the ownership bit is clear, an engine-side port with a plain linear index pushes and pops the same FIFOs. Over-pushes and over-pops are dropped and recorded in sticky per-FIFO flags.

Top module: `fifo_bypass_port`

## Requirements
- R1: After reset, every register reads 8'h00, every FIFO is empty, and `eng_grant` is 1.
- R2: The select register (address 1, bits [2:0]) maps code 6 to FIFO 0 and codes 1 to 5 to FIFOs 1 to 5. Codes 0 and 7 select no FIFO.
- R3: With control bit 3 (ownership) and control bit 0 (push mode) both set, a write to address 0 appends the byte to the selected FIFO. Bytes leave in the order they were written.
- R4: With ownership set and push mode clear, a read of address 0 returns the selected FIFO's head in the same cycle and removes it. In pop mode a data write is ignored. In push mode a data read returns 8'h00 and removes nothing.
- R5: A data access while codes 0 or 7 are selected changes no FIFO and reads 8'h00.
- R6: A push to a FIFO holding 16 bytes is dropped and sets sticky bit 0 of the flag register (address 4) for that FIFO.
- R7: A pop from an empty FIFO returns 8'h00 and sets sticky bit 1 of the flag register for that FIFO.
- R8: Control bit 2 (tx flush) and control bit 1 (rx flush) read back as 1 for exactly one cycle after being written as 1, then clear themselves. Either one empties the selected FIFO. Tx flush also clears that FIFO's overflow flag, and rx flush clears its underflow flag.
- R9: Register bits with no function read 0 and ignore writes. These are select bits [7:3], control bits [7:4], and addresses 5 to 7.
- R10: While ownership is set, `eng_grant` is 0, `eng_rdata` is 8'h00 and engine pushes and pops are ignored. While it is clear, data-register accesses change nothing and read 8'h00.
- R11: The status register (address 3) for the selected FIFO gives its count in [4:0], full in bit 5 and empty in bit 6. It reads 8'h00 when no FIFO is selected.
- R12: While ownership is clear, `eng_push` and `eng_pop` act on FIFO `eng_idx` (0 to 5). `eng_rdata` shows that FIFO's head, or 8'h00 when it is empty. Index values 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a data read pops) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte, combinational |
| eng_push | input | 1 | Engine push strobe |
| eng_pop | input | 1 | Engine pop strobe |
| eng_idx | input | 3 | Engine FIFO index |
| eng_wdata | input | 8 | Engine push byte |
| eng_rdata | output | 8 | Head byte of the engine-indexed FIFO |
| eng_grant | output | 1 | High when the engine owns the FIFOs |

## Verification
The checker assumes that `reg_wr` and `reg_rd` are never both high in one cycle. It also assumes that firmware does not rewrite a flush bit in the cycle that bit is already set. The stimulus issues exactly one register or engine operation per cycle, so both assumptions always hold. A cycle with neither a register access nor a flush is taken to leave every FIFO count unchanged while ownership is set. The bench therefore drives engine strobes in those cycles to show that they are ignored.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  localparam int DATA_W  = 8;
  localparam int N_FIFO  = 6;
  localparam int SEL_W   = 3;

  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_SEL  = 3'd1;
  localparam logic [2:0] A_CTRL = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;
  localparam logic [2:0] A_FLAG = 3'd4;

  localparam logic [7:0] SEL_MASK  = 8'h07;
  localparam logic [7:0] CTRL_KEEP = 8'h09;  // ownership + push mode
  localparam int B_PUSH = 0;
  localparam int B_RXF  = 1;
  localparam int B_TXF  = 2;
  localparam int B_OWN  = 3;

  typedef struct packed {
    logic             valid;
    logic [SEL_W-1:0] idx;
  } sel_t;

  // Non-linear code-to-FIFO mapping.
  function automatic sel_t decode_sel(input logic [SEL_W-1:0] code);
    sel_t s;
    s.valid = 1'b0;
    s.idx   = '0;
    if (code == 3'd6) begin
      s.valid = 1'b1;
      s.idx   = 3'd0;
    end else if (code >= 3'd1 && code <= 3'd5) begin
      s.valid = 1'b1;
      s.idx   = code;
    end
    return s;
  endfunction

  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  function automatic logic [7:0] pack_status(input int unsigned cnt, input logic full,
                                             input logic empty);
    return {1'b0, empty, full, 5'(cnt)};
  endfunction
endpackage

// File: rtl/fbp_regs.sv
module fbp_regs
  import fbp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [2:0]       addr,
  input  logic [7:0]       wdata,
  output logic [SEL_W-1:0] sel_code,
  output logic             push_mode,
  output logic             fw_own,
  output logic             tx_flush,
  output logic             rx_flush,
  output logic [7:0]       sel_rb,
  output logic [7:0]       ctrl_rb
);
  logic [7:0] sel_q;
  logic [7:0] ctrl_q;
  logic       wr_sel, wr_ctrl;

  assign wr_sel  = wr && (addr == A_SEL);
  assign wr_ctrl = wr && (addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '0;
      ctrl_q   <= '0;
      tx_flush <= 1'b0;
      rx_flush <= 1'b0;
    end else begin
      if (wr_sel)  sel_q  <= wdata & SEL_MASK;
      if (wr_ctrl) ctrl_q <= wdata & CTRL_KEEP;
      tx_flush <= wr_ctrl && wdata[B_TXF];
      rx_flush <= wr_ctrl && wdata[B_RXF];
    end
  end

  assign sel_code  = sel_q[SEL_W-1:0];
  assign push_mode = ctrl_q[B_PUSH];
  assign fw_own    = ctrl_q[B_OWN];
  assign sel_rb    = sel_q;
  assign ctrl_rb   = ctrl_q | {5'b0, tx_flush, rx_flush, 1'b0};
endmodule

// File: rtl/fbp_byte_fifo.sv
module fbp_byte_fifo
  import fbp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  input  logic              flush,
  input  logic              clr_ovf,
  input  logic              clr_udf,
  output logic [DATA_W-1:0] head,
  output logic [CW-1:0]     count,
  output logic              full,
  output logic              empty,
  output logic              ovf,
  output logic              udf
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     rd_ptr, wr_ptr;
  logic              do_push, do_pop, push_drop, pop_miss;

  assign empty     = (count == '0);
  assign full      = (count == CW'(DEPTH));
  assign do_pop    = pop && !empty && !flush;
  assign do_push   = push && (!full || do_pop) && !flush;
  assign push_drop = push && !do_push && !flush;
  assign pop_miss  = pop && empty && !flush;
  assign head      = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
      udf    <= 1'b0;
    end else begin
      if (flush) begin
        rd_ptr <= '0;
        wr_ptr <= '0;
        count  <= '0;
      end else begin
        if (do_push) wr_ptr <= AW'(wrap_inc(int'(wr_ptr), DEPTH));
        if (do_pop)  rd_ptr <= AW'(wrap_inc(int'(rd_ptr), DEPTH));
        count <= count + CW'(do_push) - CW'(do_pop);
      end
      if (clr_ovf)        ovf <= 1'b0;
      else if (push_drop) ovf <= 1'b1;
      if (clr_udf)        udf <= 1'b0;
      else if (pop_miss)  udf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end
endmodule

// File: rtl/fbp_route.sv
module fbp_route
  import fbp_pkg::*;
#(
  parameter int NF = N_FIFO
) (
  input  logic                      fw_own,
  input  logic                      push_mode,
  input  logic [SEL_W-1:0]          sel_code,
  input  logic                      data_wr,
  input  logic                      data_rd,
  input  logic [DATA_W-1:0]         reg_wdata,
  input  logic                      eng_push,
  input  logic                      eng_pop,
  input  logic [SEL_W-1:0]          eng_idx,
  input  logic [DATA_W-1:0]         eng_wdata,
  input  logic [NF-1:0][DATA_W-1:0] heads,
  output logic [NF-1:0]             push_vec,
  output logic [NF-1:0]             pop_vec,
  output logic [DATA_W-1:0]         fifo_wdata,
  output logic [DATA_W-1:0]         data_rdata,
  output logic [DATA_W-1:0]         eng_rdata,
  output logic                      sel_valid,
  output logic [SEL_W-1:0]          sel_idx,
  output logic                      fw_push_evt,
  output logic                      fw_pop_evt
);
  sel_t sel;
  logic eng_ok;

  assign sel         = decode_sel(sel_code);
  assign sel_valid   = sel.valid;
  assign sel_idx     = sel.idx;
  assign fw_push_evt = fw_own && push_mode && data_wr && sel.valid;
  assign fw_pop_evt  = fw_own && !push_mode && data_rd && sel.valid;
  assign eng_ok      = !fw_own && (int'(eng_idx) < NF);
  assign fifo_wdata  = fw_own ? reg_wdata : eng_wdata;

  for (genvar i = 0; i < NF; i++) begin : g_steer
    assign push_vec[i] = fw_own ? (fw_push_evt && sel.idx == SEL_W'(i))
                                : (eng_ok && eng_push && eng_idx == SEL_W'(i));
    assign pop_vec[i]  = fw_own ? (fw_pop_evt && sel.idx == SEL_W'(i))
                                : (eng_ok && eng_pop && eng_idx == SEL_W'(i));
  end

  always_comb begin
    data_rdata = '0;
    eng_rdata  = '0;
    for (int i = 0; i < NF; i++) begin
      if (fw_pop_evt && sel.idx == SEL_W'(i)) data_rdata = heads[i];
      if (eng_ok && eng_idx == SEL_W'(i))     eng_rdata  = heads[i];
    end
  end
endmodule

// File: rtl/fifo_bypass_port.sv
module fifo_bypass_port
  import fbp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        eng_push,
  input  logic        eng_pop,
  input  logic [2:0]  eng_idx,
  input  logic [7:0]  eng_wdata,
  output logic [7:0]  eng_rdata,
  output logic        eng_grant
);
  logic [SEL_W-1:0]              sel_code, sel_idx;
  logic                          push_mode, fw_own, tx_flush, rx_flush, sel_valid;
  logic [7:0]                    sel_rb, ctrl_rb, data_rdata, stat_rb, flag_rb;
  logic                          data_wr, data_rd, fw_push_evt, fw_pop_evt;
  logic [N_FIFO-1:0]             push_vec, pop_vec, full_all, empty_all, ovf_all, udf_all;
  logic [N_FIFO-1:0]             flush_vec, clr_ovf_vec, clr_udf_vec;
  logic [N_FIFO-1:0][DATA_W-1:0] head_all;
  logic [N_FIFO-1:0][CW-1:0]     cnt_all;
  logic [DATA_W-1:0]             fifo_wdata;

  assign data_wr   = reg_wr && (reg_addr == A_DATA);
  assign data_rd   = reg_rd && (reg_addr == A_DATA);
  assign eng_grant = !fw_own;

  fbp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .sel_code(sel_code), .push_mode(push_mode), .fw_own(fw_own),
    .tx_flush(tx_flush), .rx_flush(rx_flush), .sel_rb(sel_rb), .ctrl_rb(ctrl_rb)
  );

  fbp_route #(.NF(N_FIFO)) u_route (
    .fw_own(fw_own), .push_mode(push_mode), .sel_code(sel_code),
    .data_wr(data_wr), .data_rd(data_rd), .reg_wdata(reg_wdata),
    .eng_push(eng_push), .eng_pop(eng_pop), .eng_idx(eng_idx), .eng_wdata(eng_wdata),
    .heads(head_all), .push_vec(push_vec), .pop_vec(pop_vec), .fifo_wdata(fifo_wdata),
    .data_rdata(data_rdata), .eng_rdata(eng_rdata), .sel_valid(sel_valid),
    .sel_idx(sel_idx), .fw_push_evt(fw_push_evt), .fw_pop_evt(fw_pop_evt)
  );

  for (genvar i = 0; i < N_FIFO; i++) begin : g_fifo
    logic hit;
    assign hit            = sel_valid && (sel_idx == SEL_W'(i));
    assign flush_vec[i]   = hit && (tx_flush || rx_flush);
    assign clr_ovf_vec[i] = hit && tx_flush;
    assign clr_udf_vec[i] = hit && rx_flush;

    fbp_byte_fifo #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push_vec[i]), .pop(pop_vec[i]),
      .wdata(fifo_wdata), .flush(flush_vec[i]), .clr_ovf(clr_ovf_vec[i]),
      .clr_udf(clr_udf_vec[i]), .head(head_all[i]), .count(cnt_all[i]),
      .full(full_all[i]), .empty(empty_all[i]), .ovf(ovf_all[i]), .udf(udf_all[i])
    );
  end

  always_comb begin
    stat_rb = '0;
    flag_rb = '0;
    for (int i = 0; i < N_FIFO; i++) begin
      if (sel_valid && sel_idx == SEL_W'(i)) begin
        stat_rb = pack_status(int'(cnt_all[i]), full_all[i], empty_all[i]);
        flag_rb = {6'b0, udf_all[i], ovf_all[i]};
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_DATA:  reg_rdata = data_rdata;
      A_SEL:   reg_rdata = sel_rb;
      A_CTRL:  reg_rdata = ctrl_rb;
      A_STAT:  reg_rdata = stat_rb;
      A_FLAG:  reg_rdata = flag_rb;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fbp_checker.sv
module fbp_checker #(
  parameter int NF    = 6,
  parameter int CW    = 5,
  parameter int DEPTH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr,
  input logic           reg_rd,
  input logic [2:0]     reg_addr,
  input logic           wd_txf,
  input logic           wd_rxf,
  input logic [7:0]     reg_rdata,
  input logic           fw_own,
  input logic           tx_flush,
  input logic           rx_flush,
  input logic           sel_valid,
  input logic           fw_push_evt,
  input logic [NF*CW-1:0] cnt_flat,
  input logic [7:0]     eng_rdata,
  input logic           eng_grant
);
  logic ctrl_wr;
  assign ctrl_wr = reg_wr && (reg_addr == 3'd2);

  assert_tx_selfclear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush && !(ctrl_wr && wd_txf) |=> !tx_flush);
  assert_rx_selfclear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush && !(ctrl_wr && wd_rxf) |=> !rx_flush);
  assert_nosel_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == 3'd0 && !sel_valid |-> reg_rdata == 8'h00);
  assert_nosel_no_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> !fw_push_evt);
  assert_engine_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fw_own && !reg_wr && !reg_rd && !tx_flush && !rx_flush |=> $stable(cnt_flat));
  assert_engine_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fw_own |-> (eng_rdata == 8'h00) && !eng_grant);
  assert_sel_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == 3'd1 |-> reg_rdata[7:3] == 5'd0);

  for (genvar i = 0; i < NF; i++) begin : g_bound
    assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_flat[i*CW +: CW] <= CW'(DEPTH));
  end
endmodule

bind fifo_bypass_port fbp_checker #(.NF(fbp_pkg::N_FIFO), .CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .wd_txf(reg_wdata[2]), .wd_rxf(reg_wdata[1]), .reg_rdata(reg_rdata),
  .fw_own(fw_own), .tx_flush(tx_flush), .rx_flush(rx_flush), .sel_valid(sel_valid),
  .fw_push_evt(fw_push_evt), .cnt_flat(cnt_all), .eng_rdata(eng_rdata),
  .eng_grant(eng_grant)
);

// File: tb/tb_fifo_bypass_port.sv
`timescale 1ns/1ps
module tb_fifo_bypass_port;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0, eng_push = 0, eng_pop = 0;
  logic [2:0] reg_addr = 0, eng_idx = 0;
  logic [7:0] reg_wdata = 0, eng_wdata = 0;
  logic [7:0] reg_rdata, eng_rdata;
  logic eng_grant;
  int vectors = 0, fails = 0;
  logic [7:0] got;

  localparam logic [2:0] AD = 0, AS = 1, AC = 2, AT = 3, AF = 4;
  localparam logic [7:0] PUSH = 8'h01, RXF = 8'h02, TXF = 8'h04, OWN = 8'h08;

  always #2.5 clk = ~clk;

  fifo_bypass_port dut (.*);

  function automatic int idx_of(input int code);
    if (code == 6) return 0;
    if (code >= 1 && code <= 5) return code;
    return -1;
  endfunction
  function automatic logic [7:0] stat_of(input int cnt);
    return 8'(cnt) | ((cnt == 16) ? 8'h20 : 8'h00) | ((cnt == 0) ? 8'h40 : 8'h00);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask
  task automatic eng(input logic p, input logic q, input logic [2:0] i,
                     input logic [7:0] d, output logic [7:0] r);
    eng_push = p; eng_pop = q; eng_idx = i; eng_wdata = d;
    #1 r = eng_rdata;
    @(negedge clk); eng_push = 0; eng_pop = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 5; a++) begin rd(3'(a), got); chk("R1", got, 8'h00); end
    chk("R1 grant", {7'b0, eng_grant}, 8'h01);
    // R9 reserved bits
    wr(AS, 8'hFF); rd(AS, got); chk("R9 sel", got, 8'h07);
    wr(AC, 8'hF9); rd(AC, got); chk("R9 ctrl", got, 8'h09);
    wr(3'd5, 8'hAA); rd(3'd5, got); chk("R9 addr5", got, 8'h00);
    // R2/R3 select sweep in push mode
    wr(AC, OWN | PUSH);
    for (int c = 0; c < 8; c++) begin wr(AS, 8'(c)); wr(AD, 8'(8'h40 + c)); end
    for (int c = 0; c < 8; c++) begin
      wr(AS, 8'(c)); rd(AT, got);
      chk("R11 R2 stat", got, idx_of(c) < 0 ? 8'h00 : stat_of(1));
    end
    // R2/R12 engine sees mapped bytes
    wr(AC, 8'h00);
    chk("R10 grant", {7'b0, eng_grant}, 8'h01);
    for (int i = 0; i < 6; i++) begin
      eng(0, 1, 3'(i), 0, got); chk("R2 R12 eng pop", got, 8'(8'h40 + (i == 0 ? 6 : i)));
      eng(0, 0, 3'(i), 0, got); chk("R12 eng empty", got, 8'h00);
    end
    // R6 fill code 3 past full
    wr(AC, OWN | PUSH); wr(AS, 8'd3);
    for (int k = 0; k < 17; k++) begin
      wr(AD, 8'(k * 7 + 3)); rd(AT, got); chk("R6 R11 fill", got, stat_of(k < 16 ? k + 1 : 16));
    end
    rd(AF, got); chk("R6 ovf", got, 8'h01);
    // R4/R7 pop in order then underflow
    wr(AC, OWN);
    for (int k = 0; k < 16; k++) begin rd(AD, got); chk("R3 R4 order", got, 8'(k * 7 + 3)); end
    rd(AD, got); chk("R7 empty pop", got, 8'h00);
    rd(AF, got); chk("R7 udf", got, 8'h03);
    wr(AD, 8'h99); rd(AT, got); chk("R4 write in pop mode", got, stat_of(0));
    wr(AC, OWN | PUSH); rd(AD, got); chk("R4 read in push mode", got, 8'h00);
    wr(AD, 8'h5A); rd(AD, got); chk("R4 read no pop", got, 8'h00);
    rd(AT, got); chk("R4 count", got, stat_of(1));
    // R8 self-clearing flushes
    wr(AC, OWN | PUSH | TXF); rd(AC, got); chk("R8 tx set", got, 8'h0D);
    rd(AC, got); chk("R8 tx clear", got, 8'h09);
    rd(AT, got); chk("R8 tx empties", got, stat_of(0));
    rd(AF, got); chk("R8 tx clears ovf", got, 8'h02);
    wr(AD, 8'h11);
    wr(AC, OWN | RXF); rd(AC, got); chk("R8 rx set", got, 8'h0A);
    rd(AC, got); chk("R8 rx clear", got, 8'h08);
    rd(AT, got); chk("R8 rx empties", got, stat_of(0));
    rd(AF, got); chk("R8 rx clears udf", got, 8'h00);
    // R5 no selection
    wr(AC, OWN | PUSH);
    for (int c = 0; c < 8; c += 7) begin
      wr(AS, 8'(c)); wr(AD, 8'h77);
      wr(AC, OWN); rd(AD, got); chk("R5 read", got, 8'h00);
      wr(AC, OWN | PUSH);
    end
    for (int c = 1; c < 7; c++) begin wr(AS, 8'(c)); rd(AT, got); chk("R5 untouched", got, stat_of(0)); end
    // R10 ownership
    wr(AC, OWN); wr(AS, 8'd2);
    eng(1, 0, 3'd2, 8'h33, got); chk("R10 eng_rdata", got, 8'h00);
    chk("R10 grant low", {7'b0, eng_grant}, 8'h00);
    rd(AT, got); chk("R10 eng blocked", got, stat_of(0));
    wr(AC, PUSH); wr(AD, 8'h44); rd(AT, got); chk("R10 fw blocked", got, stat_of(0));
    rd(AD, got); chk("R10 fw read", got, 8'h00);
    // R12 engine sweep
    for (int i = 0; i < 6; i++)
      for (int j = 0; j <= i; j++) eng(1, 0, 3'(i), 8'(i * 16 + j), got);
    eng(1, 0, 3'd6, 8'hEE, got); eng(1, 1, 3'd7, 8'hEE, got);
    chk("R12 idx7", got, 8'h00);
    for (int c = 1; c < 7; c++) begin
      wr(AS, 8'(c)); rd(AT, got); chk("R12 count", got, stat_of(idx_of(c) + 1));
    end
    for (int i = 0; i < 6; i++)
      for (int j = 0; j <= i; j++) begin
        eng(0, 1, 3'(i), 0, got); chk("R12 order", got, 8'(i * 16 + j));
      end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule